// File: doc/BRIEF.md
# Non-periodic split transaction buffer

This block sits inside a speed-translating hub and parks bulk and control transfers that the high-speed host hands over as start-splits. Each start-split carries a token (OUT, IN or SETUP), a device address, an endpoint number and, for OUT and SETUP, a payload word. The block places the transfer in one of `NSLOT` transaction slots and answers ACK, so the host moves on to polling with complete-splits. These slots are used only for bulk and control traffic. Periodic transfers have separate storage, which is not part of this block.

A downstream issue state machine hands stored transfers one at a time to the full/low-speed bus engine, in the order they arrived. It does this only while the engine reports idle and no periodic work is pending. The engine returns a result code (ACK, NAK, STALL or DATA) and an optional IN data word. The block keeps that result in the slot until the host's matching complete-split collects it. Slots are matched by address, endpoint and direction. A slot is released once its result has been delivered. Flow control relies only on the returned handshakes. The block never retries, and it has no PING path.

The issue state machine has three states. In `ISS_IDLE` it leaves on "go" (a transfer is queued, the engine is idle and no periodic work is pending) to `ISS_SEND`. `ISS_SEND` always moves to `ISS_WAIT` after one cycle. `ISS_WAIT` returns to `ISS_IDLE` on "done". Each slot has four states: FREE, PEND (accepted), BUSY (handed downstream) and DONE (result held). The transitions are FREE→PEND on accept, PEND→BUSY on go, BUSY→DONE on done, and DONE→FREE on delivery.

Top module: `async_split_buffer`

## Requirements
- R1: After reset and while reset is held, `hs_rsp_valid` and `ds_req_valid` are 0 and every slot is free. A complete-split sent after reset therefore gets NAK, even if a transfer had been accepted before the reset.
- R2: A start-split that finds a free slot, with no held slot for the same key, is answered with ACK (code 0) one cycle later. Its token, key and payload are stored and later presented on the `ds_req_*` ports. Token codes are OUT=0, IN=1 and SETUP=2.
- R3: A start-split that arrives when all slots are occupied is answered with NAK (code 1), and nothing is stored.
- R4: A start-split whose key matches a slot already held is answered with NAK, and the held slot is unchanged.
- R5: A transfer is presented downstream only in the cycle after one in which `per_busy`=0 and `ds_idle`=1 while the machine was in `ISS_IDLE`. `ds_req_valid` is high for exactly one cycle per transfer.
- R6: Stored transfers are issued downstream in the order their start-splits were accepted.
- R7: A complete-split that matches a slot whose downstream result has not yet arrived is answered with NYET (code 2), and the slot stays held.
- R8: A complete-split that matches a slot holding a result returns the stored code. For DATA (code 4), `hs_rsp_data` carries the returned word. The slot is then freed.
- R9: A complete-split that matches no held slot is answered with NAK.
- R10: The match key is address, endpoint and direction, where IN is one direction and OUT and SETUP are the other. OUT and IN transfers to the same endpoint occupy separate slots.
- R11: Every host request gets exactly one response, with `hs_rsp_valid` high in the next cycle.
- R12: A NAK or STALL (code 3) returned by the downstream engine is passed to the host unchanged on the complete-split. The block does not retry it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req_valid | input | 1 | Host request present this cycle |
| hs_req_complete | input | 1 | 0 = start-split, 1 = complete-split |
| hs_req_tok | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| hs_req_addr | input | 7 | Device address |
| hs_req_ep | input | 4 | Endpoint number |
| hs_req_data | input | DATA_W | Payload for OUT/SETUP start-splits |
| hs_rsp_valid | output | 1 | Response valid, one cycle after the request |
| hs_rsp_code | output | 3 | 0 ACK, 1 NAK, 2 NYET, 3 STALL, 4 DATA |
| hs_rsp_data | output | DATA_W | IN data when the code is DATA, else 0 |
| per_busy | input | 1 | Periodic work pending; blocks downstream issue |
| ds_idle | input | 1 | Downstream engine can take a transfer |
| ds_req_valid | output | 1 | One-cycle transfer request to the engine |
| ds_req_tok | output | 2 | Token of the issued transfer |
| ds_req_addr | output | 7 | Address of the issued transfer |
| ds_req_ep | output | 4 | Endpoint of the issued transfer |
| ds_req_data | output | DATA_W | Payload of the issued transfer |
| ds_done | input | 1 | Engine reports the result |
| ds_rsp_code | input | 3 | Result: ACK, NAK, STALL or DATA |
| ds_rsp_data | input | DATA_W | IN data returned by the engine |

## Verification
The start-split path is exercised with a fresh key, an opposite-direction twin of a held key, an exact duplicate and an arrival into a full buffer. Together these separate the free-slot check from the duplicate-key check. The complete-split path is probed in three situations: before the transfer is issued, after its result is in, and after the slot has been released. This shows NYET, result delivery and the freed case behave differently.

Downstream issue is tested with the engine busy, with periodic work pending, and with both released in a known cycle, so a one-cycle slip in gating is caught. Results of ACK, DATA, NAK and STALL are returned for transfers of all three token types, in a known arrival order. A reset in the middle of a transfer confirms that an accepted transfer does not survive reset.

// File: rtl/asb_pkg.sv
package asb_pkg;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2
    } tok_e;

    typedef enum logic [2:0] {
        RSP_ACK   = 3'd0,
        RSP_NAK   = 3'd1,
        RSP_NYET  = 3'd2,
        RSP_STALL = 3'd3,
        RSP_DATA  = 3'd4
    } rsp_e;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_BUSY = 2'd2,
        SLOT_DONE = 2'd3
    } slot_st_e;

    typedef enum logic [1:0] {
        ISS_IDLE = 2'd0,
        ISS_SEND = 2'd1,
        ISS_WAIT = 2'd2
    } iss_st_e;

    localparam int ADDR_W = 7;
    localparam int EP_W   = 4;

    function automatic logic tok_is_in(input logic [1:0] tok);
        return tok == TOK_IN;
    endfunction

endpackage

// File: rtl/asb_slot_store.sv
module asb_slot_store
    import asb_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int DATA_W = 8,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    // allocation from an accepted start-split
    input  logic              alloc_en,
    input  logic [1:0]        alloc_tok,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [EP_W-1:0]   alloc_ep,
    input  logic [DATA_W-1:0] alloc_data,
    // handed to the downstream engine
    input  logic              issue_en,
    input  logic [SW-1:0]     issue_idx,
    // downstream result capture
    input  logic              done_en,
    input  logic [SW-1:0]     done_idx,
    input  logic [2:0]        done_code,
    input  logic [DATA_W-1:0] done_data,
    // release after delivery
    input  logic              free_en,
    // key lookup for the current host request
    input  logic [ADDR_W-1:0] key_addr,
    input  logic [EP_W-1:0]   key_ep,
    input  logic              key_dir,
    output logic              any_free,
    output logic [SW-1:0]     first_free,
    output logic              hit,
    output logic [SW-1:0]     hit_idx,
    output slot_st_e          hit_st,
    output logic [2:0]        hit_code,
    output logic [DATA_W-1:0] hit_data,
    // read port for the slot being issued
    input  logic [SW-1:0]     rd_idx,
    output logic [1:0]        rd_tok,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [EP_W-1:0]   rd_ep,
    output logic [DATA_W-1:0] rd_data
);

    slot_st_e          st_q    [NSLOT];
    logic [1:0]        tok_q   [NSLOT];
    logic [ADDR_W-1:0] addr_q  [NSLOT];
    logic [EP_W-1:0]   ep_q    [NSLOT];
    logic [DATA_W-1:0] pdata_q [NSLOT];
    logic [2:0]        rcode_q [NSLOT];
    logic [DATA_W-1:0] rdata_q [NSLOT];

    logic [NSLOT-1:0] free_vec;
    logic [NSLOT-1:0] match_vec;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign free_vec[g]  = (st_q[g] == SLOT_FREE);
        assign match_vec[g] = (st_q[g] != SLOT_FREE)
                            && (addr_q[g] == key_addr)
                            && (ep_q[g] == key_ep)
                            && (tok_is_in(tok_q[g]) == key_dir);
    end

    always_comb begin
        any_free   = |free_vec;
        first_free = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (free_vec[i]) first_free = SW'(i);
        end
    end

    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = SW'(i);
        end
    end

    assign hit_st   = st_q[hit_idx];
    assign hit_code = rcode_q[hit_idx];
    assign hit_data = rdata_q[hit_idx];

    assign rd_tok  = tok_q[rd_idx];
    assign rd_addr = addr_q[rd_idx];
    assign rd_ep   = ep_q[rd_idx];
    assign rd_data = pdata_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                st_q[i]    <= SLOT_FREE;
                tok_q[i]   <= '0;
                addr_q[i]  <= '0;
                ep_q[i]    <= '0;
                pdata_q[i] <= '0;
                rcode_q[i] <= '0;
                rdata_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc_en && first_free == SW'(i)) begin
                    st_q[i]    <= SLOT_PEND;
                    tok_q[i]   <= alloc_tok;
                    addr_q[i]  <= alloc_addr;
                    ep_q[i]    <= alloc_ep;
                    pdata_q[i] <= alloc_data;
                end
                if (issue_en && issue_idx == SW'(i)) begin
                    st_q[i] <= SLOT_BUSY;
                end
                if (done_en && done_idx == SW'(i)) begin
                    st_q[i]    <= SLOT_DONE;
                    rcode_q[i] <= done_code;
                    rdata_q[i] <= done_data;
                end
                if (free_en && hit_idx == SW'(i)) begin
                    st_q[i] <= SLOT_FREE;
                end
            end
        end
    end

endmodule

// File: rtl/asb_order_fifo.sv
module asb_order_fifo #(
    parameter int DEPTH = 4,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [SW-1:0] push_idx,
    input  logic          pop,
    output logic [SW-1:0] head,
    output logic          empty,
    output logic          full
);

    logic [SW-1:0] mem_q [DEPTH];
    logic [SW-1:0] wr_q;
    logic [SW-1:0] rd_q;
    logic [SW:0]   cnt_q;

    function automatic logic [SW-1:0] bump(input logic [SW-1:0] p);
        return (p == SW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (SW+1)'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_idx;
                wr_q        <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/asb_issue_fsm.sv
module asb_issue_fsm
    import asb_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          queue_empty,
    input  logic [SW-1:0] queue_head,
    input  logic          per_busy,
    input  logic          ds_idle,
    input  logic          ds_done,
    output logic          pop,
    output logic          issue_en,
    output logic [SW-1:0] issue_idx,
    output logic [SW-1:0] cur_idx,
    output logic          ds_valid,
    output logic          done_en
);

    iss_st_e       state_q;
    iss_st_e       state_d;
    logic [SW-1:0] cur_q;
    logic          go;

    assign go = (state_q == ISS_IDLE) && !queue_empty && !per_busy && ds_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (go) cur_q <= queue_head;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISS_IDLE: if (go)      state_d = ISS_SEND;
            ISS_SEND:              state_d = ISS_WAIT;
            ISS_WAIT: if (ds_done) state_d = ISS_IDLE;
            default:               state_d = ISS_IDLE;
        endcase
    end

    always_comb begin
        pop       = 1'b0;
        issue_en  = 1'b0;
        ds_valid  = 1'b0;
        done_en   = 1'b0;
        issue_idx = queue_head;
        cur_idx   = cur_q;
        unique case (state_q)
            ISS_IDLE: begin
                pop      = go;
                issue_en = go;
            end
            ISS_SEND: ds_valid = 1'b1;
            ISS_WAIT: done_en  = ds_done;
            default: ;
        endcase
    end

endmodule

// File: rtl/async_split_buffer.sv
module async_split_buffer
    import asb_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int DATA_W = 8,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_req_valid,
    input  logic              hs_req_complete,
    input  logic [1:0]        hs_req_tok,
    input  logic [6:0]        hs_req_addr,
    input  logic [3:0]        hs_req_ep,
    input  logic [DATA_W-1:0] hs_req_data,
    output logic              hs_rsp_valid,
    output logic [2:0]        hs_rsp_code,
    output logic [DATA_W-1:0] hs_rsp_data,
    input  logic              per_busy,
    input  logic              ds_idle,
    output logic              ds_req_valid,
    output logic [1:0]        ds_req_tok,
    output logic [6:0]        ds_req_addr,
    output logic [3:0]        ds_req_ep,
    output logic [DATA_W-1:0] ds_req_data,
    input  logic              ds_done,
    input  logic [2:0]        ds_rsp_code,
    input  logic [DATA_W-1:0] ds_rsp_data
);

    logic              is_start;
    logic              is_comp;
    logic              any_free;
    logic [SW-1:0]     first_free;
    logic              hit;
    logic [SW-1:0]     hit_idx;
    slot_st_e          hit_st;
    logic [2:0]        hit_code;
    logic [DATA_W-1:0] hit_data;
    logic              accept;
    logic              deliver;
    logic              fifo_full;
    logic              fifo_empty;
    logic [SW-1:0]     fifo_head;
    logic              pop;
    logic              issue_en;
    logic [SW-1:0]     issue_idx;
    logic [SW-1:0]     cur_idx;
    logic              done_en;
    logic [2:0]        code_d;
    logic [DATA_W-1:0] data_d;

    assign is_start = hs_req_valid && !hs_req_complete;
    assign is_comp  = hs_req_valid &&  hs_req_complete;
    assign accept   = is_start && !hit && any_free;
    assign deliver  = is_comp && hit && (hit_st == SLOT_DONE);

    asb_slot_store #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (accept),
        .alloc_tok  (hs_req_tok),
        .alloc_addr (hs_req_addr),
        .alloc_ep   (hs_req_ep),
        .alloc_data (hs_req_data),
        .issue_en   (issue_en),
        .issue_idx  (issue_idx),
        .done_en    (done_en),
        .done_idx   (cur_idx),
        .done_code  (ds_rsp_code),
        .done_data  (ds_rsp_data),
        .free_en    (deliver),
        .key_addr   (hs_req_addr),
        .key_ep     (hs_req_ep),
        .key_dir    (tok_is_in(hs_req_tok)),
        .any_free   (any_free),
        .first_free (first_free),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .hit_st     (hit_st),
        .hit_code   (hit_code),
        .hit_data   (hit_data),
        .rd_idx     (cur_idx),
        .rd_tok     (ds_req_tok),
        .rd_addr    (ds_req_addr),
        .rd_ep      (ds_req_ep),
        .rd_data    (ds_req_data)
    );

    asb_order_fifo #(.DEPTH(NSLOT)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_idx (first_free),
        .pop      (pop),
        .head     (fifo_head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    asb_issue_fsm #(.NSLOT(NSLOT)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .queue_empty (fifo_empty),
        .queue_head  (fifo_head),
        .per_busy    (per_busy),
        .ds_idle     (ds_idle),
        .ds_done     (ds_done),
        .pop         (pop),
        .issue_en    (issue_en),
        .issue_idx   (issue_idx),
        .cur_idx     (cur_idx),
        .ds_valid    (ds_req_valid),
        .done_en     (done_en)
    );

    // response selection
    always_comb begin
        code_d = RSP_NAK;
        data_d = '0;
        if (is_start) begin
            code_d = accept ? RSP_ACK : RSP_NAK;
        end else if (is_comp && hit) begin
            if (hit_st == SLOT_DONE) begin
                code_d = hit_code;
                if (hit_code == RSP_DATA) data_d = hit_data;
            end else begin
                code_d = RSP_NYET;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_rsp_valid <= 1'b0;
            hs_rsp_code  <= '0;
            hs_rsp_data  <= '0;
        end else begin
            hs_rsp_valid <= hs_req_valid;
            hs_rsp_code  <= hs_req_valid ? code_d : '0;
            hs_rsp_data  <= hs_req_valid ? data_d : '0;
        end
    end

endmodule

// File: rtl/asb_checker.sv
module asb_checker
    import asb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hs_req_valid,
    input logic       is_start,
    input logic       is_comp,
    input logic       any_free,
    input logic       hit,
    input slot_st_e   hit_st,
    input logic       hs_rsp_valid,
    input logic [2:0] hs_rsp_code,
    input logic       ds_req_valid,
    input logic       per_busy,
    input logic       ds_idle,
    input logic       fifo_push,
    input logic       fifo_full
);

    assert_rsp_next_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hs_req_valid |=> hs_rsp_valid);

    assert_full_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_start && !any_free && !hit) |=> (hs_rsp_code == RSP_NAK));

    assert_dup_nak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_start && hit) |=> (hs_rsp_code == RSP_NAK));

    assert_pending_nyet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_comp && hit && hit_st != SLOT_DONE) |=> (hs_rsp_code == RSP_NYET));

    assert_unmatched_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_comp && !hit) |=> (hs_rsp_code == RSP_NAK));

    assert_issue_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_req_valid) |-> $past(!per_busy && ds_idle));

    assert_issue_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid |=> !ds_req_valid);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_full));

endmodule

bind async_split_buffer asb_checker u_asb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_req_valid (hs_req_valid),
    .is_start     (is_start),
    .is_comp      (is_comp),
    .any_free     (any_free),
    .hit          (hit),
    .hit_st       (hit_st),
    .hs_rsp_valid (hs_rsp_valid),
    .hs_rsp_code  (hs_rsp_code),
    .ds_req_valid (ds_req_valid),
    .per_busy     (per_busy),
    .ds_idle      (ds_idle),
    .fifo_push    (accept),
    .fifo_full    (fifo_full)
);

// File: tb/test_async_split_buffer.sv
module test_async_split_buffer;

    localparam int NSLOT  = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hs_req_valid = 1'b0;
    logic              hs_req_complete = 1'b0;
    logic [1:0]        hs_req_tok = '0;
    logic [6:0]        hs_req_addr = '0;
    logic [3:0]        hs_req_ep = '0;
    logic [DATA_W-1:0] hs_req_data = '0;
    logic              hs_rsp_valid;
    logic [2:0]        hs_rsp_code;
    logic [DATA_W-1:0] hs_rsp_data;
    logic              per_busy = 1'b1;
    logic              ds_idle = 1'b0;
    logic              ds_req_valid;
    logic [1:0]        ds_req_tok;
    logic [6:0]        ds_req_addr;
    logic [3:0]        ds_req_ep;
    logic [DATA_W-1:0] ds_req_data;
    logic              ds_done = 1'b0;
    logic [2:0]        ds_rsp_code = '0;
    logic [DATA_W-1:0] ds_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int served = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    async_split_buffer #(.NSLOT(NSLOT), .DATA_W(DATA_W)) i_async_split_buffer (.*);

    // kind, tok, addr, ep, data, expected code
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 2'd0, 7'h05, 4'h1, 8'hA1, 3'd0},
        {1'b0, 2'd1, 7'h05, 4'h1, 8'h00, 3'd0},
        {1'b1, 2'd0, 7'h05, 4'h1, 8'h00, 3'd2},
        {1'b0, 2'd0, 7'h05, 4'h1, 8'hFF, 3'd1},
        {1'b1, 2'd1, 7'h07, 4'h2, 8'h00, 3'd1},
        {1'b0, 2'd2, 7'h06, 4'h0, 8'hC3, 3'd0},
        {1'b0, 2'd1, 7'h06, 4'h3, 8'h00, 3'd0},
        {1'b0, 2'd0, 7'h09, 4'h1, 8'h11, 3'd1},
        {1'b1, 2'd1, 7'h06, 4'h3, 8'h00, 3'd2}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R10";
            2: return "R7";
            3: return "R4";
            4: return "R9";
            5: return "R2";
            6: return "R2";
            7: return "R3";
            default: return "R7";
        endcase
    endfunction

    // downstream expectations in issue order (R6) and the results returned
    localparam int NDS = 5;
    localparam logic [1:0] DS_TOK  [NDS] = '{2'd0, 2'd1, 2'd2, 2'd1, 2'd0};
    localparam logic [6:0] DS_ADDR [NDS] = '{7'h05, 7'h05, 7'h06, 7'h06, 7'h0A};
    localparam logic [3:0] DS_EP   [NDS] = '{4'h1, 4'h1, 4'h0, 4'h3, 4'h2};
    localparam logic [7:0] DS_PAY  [NDS] = '{8'hA1, 8'h00, 8'hC3, 8'h00, 8'h5A};
    localparam logic [2:0] DS_RC   [NDS] = '{3'd0, 3'd4, 3'd1, 3'd3, 3'd0};
    localparam logic [7:0] DS_RD   [NDS] = '{8'h00, 8'h3C, 8'h00, 8'h00, 8'h00};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host(input logic comp, input logic [1:0] tok, input logic [6:0] a,
                        input logic [3:0] e, input logic [7:0] d,
                        output logic [2:0] code, output logic [7:0] data);
        hs_req_valid    = 1'b1;
        hs_req_complete = comp;
        hs_req_tok      = tok;
        hs_req_addr     = a;
        hs_req_ep       = e;
        hs_req_data     = d;
        @(negedge clk);
        hs_req_valid = 1'b0;
        check(hs_rsp_valid == 1'b1, "R11", "response valid", int'(hs_rsp_valid), 1);
        code = hs_rsp_code;
        data = hs_rsp_data;
    endtask

    // downstream engine model
    initial begin
        forever begin
            @(negedge clk);
            if (ds_req_valid && rst_n) begin
                if (served < NDS) begin
                    check(ds_req_tok == DS_TOK[served] && ds_req_addr == DS_ADDR[served]
                          && ds_req_ep == DS_EP[served], "R6", "issue order key",
                          int'({ds_req_tok, ds_req_addr, ds_req_ep}),
                          int'({DS_TOK[served], DS_ADDR[served], DS_EP[served]}));
                    if (DS_TOK[served] != 2'd1)
                        check(ds_req_data == DS_PAY[served], "R2", "payload",
                              int'(ds_req_data), int'(DS_PAY[served]));
                    @(negedge clk);
                    ds_done     = 1'b1;
                    ds_rsp_code = DS_RC[served];
                    ds_rsp_data = DS_RD[served];
                    @(negedge clk);
                    ds_done = 1'b0;
                    served++;
                end else begin
                    check(1'b0, "R6", "unexpected issue", served, NDS);
                end
            end
        end
    end

    task automatic wait_served(input int n);
        while (served < n) @(negedge clk);
    endtask

    initial begin
        logic [2:0] code;
        logic [7:0] data;
        repeat (3) @(negedge clk);
        check(hs_rsp_valid == 1'b0 && ds_req_valid == 1'b0, "R1", "outputs in reset",
              int'({hs_rsp_valid, ds_req_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hs_rsp_valid == 1'b0 && ds_req_valid == 1'b0, "R1", "outputs after reset",
              int'({hs_rsp_valid, ds_req_valid}), 0);

        // table walk with periodic work pending: nothing may issue
        for (int i = 0; i < NV; i++) begin
            host(VEC[i][24], VEC[i][23:22], VEC[i][21:15], VEC[i][14:11], VEC[i][10:3],
                 code, data);
            check(code == VEC[i][2:0], vec_tag(i), $sformatf("table vector %0d", i),
                  int'(code), int'(VEC[i][2:0]));
            check(ds_req_valid == 1'b0, "R5", "no issue while periodic pending",
                  int'(ds_req_valid), 0);
        end

        // R3: rejected entry was not stored
        host(1'b1, 2'd0, 7'h09, 4'h1, 8'h00, code, data);
        check(code == 3'd1, "R3", "rejected start-split not stored", int'(code), 1);

        // R5: periodic clear but engine busy
        per_busy = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(ds_req_valid == 1'b0, "R5", "no issue while engine busy",
                  int'(ds_req_valid), 0);
        end
        ds_idle = 1'b1;
        @(negedge clk);
        check(ds_req_valid == 1'b1, "R5", "issue one cycle after release",
              int'(ds_req_valid), 1);

        wait_served(1);
        host(1'b1, 2'd0, 7'h05, 4'h1, 8'h00, code, data);
        check(code == 3'd0, "R8", "OUT result ACK delivered", int'(code), 0);
        host(1'b1, 2'd0, 7'h05, 4'h1, 8'h00, code, data);
        check(code == 3'd1, "R9", "slot freed after delivery", int'(code), 1);

        wait_served(2);
        host(1'b1, 2'd1, 7'h05, 4'h1, 8'h00, code, data);
        check(code == 3'd4, "R8", "IN result code DATA", int'(code), 4);
        check(data == 8'h3C, "R8", "IN result data", int'(data), 8'h3C);

        wait_served(3);
        host(1'b1, 2'd2, 7'h06, 4'h0, 8'h00, code, data);
        check(code == 3'd1, "R12", "downstream NAK relayed", int'(code), 1);

        wait_served(4);
        host(1'b1, 2'd1, 7'h06, 4'h3, 8'h00, code, data);
        check(code == 3'd3, "R12", "downstream STALL relayed", int'(code), 3);

        // R5 exact gating by periodic work
        per_busy = 1'b1;
        host(1'b0, 2'd0, 7'h0A, 4'h2, 8'h5A, code, data);
        check(code == 3'd0, "R2", "accept with periodic pending", int'(code), 0);
        repeat (4) begin
            @(negedge clk);
            check(ds_req_valid == 1'b0, "R5", "held by periodic work",
                  int'(ds_req_valid), 0);
        end
        per_busy = 1'b0;
        @(negedge clk);
        check(ds_req_valid == 1'b1, "R5", "issue after periodic clears",
              int'(ds_req_valid), 1);
        @(negedge clk);
        check(ds_req_valid == 1'b0, "R5", "request is a single pulse",
              int'(ds_req_valid), 0);
        wait_served(5);
        host(1'b1, 2'd0, 7'h0A, 4'h2, 8'h00, code, data);
        check(code == 3'd0, "R8", "fifth transfer delivered", int'(code), 0);

        // R1: reset discards an accepted transfer
        per_busy = 1'b1;
        host(1'b0, 2'd0, 7'h11, 4'h4, 8'h77, code, data);
        check(code == 3'd0, "R2", "accept before reset", int'(code), 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(hs_rsp_valid == 1'b0 && ds_req_valid == 1'b0, "R1", "outputs in mid reset",
              int'({hs_rsp_valid, ds_req_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        host(1'b1, 2'd0, 7'h11, 4'h4, 8'h00, code, data);
        check(code == 3'd1, "R1", "slot cleared by reset", int'(code), 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule